// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software progress with a 7-bit down-counter. The counter ticks at a slow rate: the clock goes through a fixed power-of-two pre-divider (4096 by default) and then through a selectable divide of 1, 2, 4 or 8. Software must refresh the counter inside a window. The refresh is too late once the count has stepped from 0x40 to 0x3F. It is too early while the count is still above a programmed window value. Either fault, once the watchdog is armed, raises a one-cycle reset request. An early-warning flag is set when the count reaches 0x40, and it can drive an interrupt output.

Software uses three simple write strobes. The control write arms the watchdog and reloads the counter. The configuration write sets the window, the timebase and the interrupt enable. The flag write clears the warning flag. Each register also has a read port.

Top module: `win_watchdog`

## Requirements
- R1: After reset the control read is 0x7F (disarmed, count 0x7F), the configuration read is 0x07F (window 0x7F, timebase 0, interrupt disabled), and the flag, `rstReq` and `irq` are all 0.
- R2: While armed, the tick that moves the count from 0x40 to 0x3F raises `rstReq` for exactly one cycle, in the same cycle the count reads 0x3F.
- R3: A control write while armed and the current count is greater than the window raises `rstReq` in the cycle after the write.
- R4: A control write while armed, with count between 0x40 and the window inclusive and load bit 6 set, raises no `rstReq` and loads the counter.
- R5: While disarmed, `rstReq` stays 0 except as given by R7 for an arming write.
- R6: The count decrements once every 2^(PRE_LOG2+timebase) clocks, counted from the last control write, which restarts the divider.
- R7: A control write with load bit 6 clear raises `rstReq` in the next cycle if the watchdog is armed or the write arms it.
- R8: The flag is set by the tick that takes the count from 0x41 to 0x40, whether armed or not. A flag write with data 0 clears it and a write of 1 has no effect. `irq` is the flag ANDed with the interrupt enable.
- R9: Once armed, the watchdog stays armed until block reset, whatever is written to control bit 7.
- R10: The control layout is bit 7 arm and bits 6:0 count. The configuration layout is bit 9 interrupt enable, bits 8:7 timebase and bits 6:0 window. Reads return the same layouts.
- R11: The count keeps decrementing while disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low block reset |
| ctrlWe | input | 1 | Control write strobe |
| ctrlWdata | input | 8 | Control write data {arm, count} |
| cfgWe | input | 1 | Configuration write strobe |
| cfgWdata | input | 10 | Configuration write data {irqEn, timebase, window} |
| flagWe | input | 1 | Flag write strobe |
| flagWdata | input | 1 | Flag write data (0 clears) |
| ctrlRdata | output | 8 | Control read {armed, count} |
| cfgRdata | output | 10 | Configuration read |
| flagRdata | output | 1 | Early-warning flag |
| rstReq | output | 1 | Registered reset request pulse |
| irq | output | 1 | Early-warning interrupt |

## Verification
The assertions assume that write strobes are single-cycle qualifiers sampled on the rising edge. They also assume that a write which coincides with a tick takes priority for the counter, so no underflow is judged on that edge. The random stimulus keeps every wait short enough that the count never drops below 0x40 before the next refresh. Window and load values are drawn from 0x40 to 0x7F, and the timebase is changed only between sequences, just before a fresh reload. A cleared bit 6 in a load appears only in a directed case.

// File: rtl/wwdg_pkg.sv
package wwdg_pkg;
  typedef struct packed {
    logic loadCnt;
    logic loadCfg;
    logic restartPre;
  } wdStrobe_t;
endpackage

// File: rtl/wwdg_datapath.sv
module wwdg_datapath
  import wwdg_pkg::*;
#(
  parameter int PRE_LOG2 = 12,
  parameter int TB_W     = 2,
  parameter int CNT_W    = 7
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  wdStrobe_t               strb,
  input  logic [CNT_W-1:0]        loadVal,
  input  logic [CNT_W+TB_W:0]     cfgIn,
  output logic [CNT_W-1:0]        cnt,
  output logic [CNT_W-1:0]        window,
  output logic [TB_W-1:0]         tb,
  output logic                    irqEn,
  output logic                    tick
);
  localparam int PRE_W = PRE_LOG2 + (1 << TB_W) - 1;
  localparam logic [PRE_W-1:0] PRE_ONE = 1;
  localparam logic [CNT_W-1:0] CNT_ONE = 1;

  logic [PRE_W-1:0] preQ;
  logic [PRE_W-1:0] preLimit;

  // terminal count of the divider depends on the selected timebase
  always_comb begin
    preLimit = (PRE_ONE << (PRE_LOG2 + int'(tb))) - PRE_ONE;
    tick     = (preQ >= preLimit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         preQ <= '0;
    else if (strb.restartPre || tick)  preQ <= '0;
    else                               preQ <= preQ + PRE_ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cnt <= '1;
    else if (strb.loadCnt) cnt <= loadVal;
    else if (tick)         cnt <= cnt - CNT_ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      window <= '1;
      tb     <= '0;
      irqEn  <= 1'b0;
    end else if (strb.loadCfg) begin
      {irqEn, tb, window} <= cfgIn;
    end
  end
endmodule

// File: rtl/wwdg_control.sv
module wwdg_control
  import wwdg_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlWe,
  input  logic [CNT_W:0]   ctrlWdata,
  input  logic             cfgWe,
  input  logic             flagWe,
  input  logic             flagWdata,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] window,
  input  logic             irqEn,
  input  logic             tick,
  output wdStrobe_t        strb,
  output logic             activeQ,
  output logic             flagQ,
  output logic             rstReq,
  output logic             irq
);
  localparam logic [CNT_W-1:0] THRESH = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic [CNT_W-1:0] NEAR   = {1'b1, {(CNT_W-2){1'b0}}, 1'b1};

  logic armWrite, earlyReload, badLoad, underflow, warnSet;

  always_comb begin
    strb.loadCnt    = ctrlWe;
    strb.restartPre = ctrlWe;
    strb.loadCfg    = cfgWe;
    armWrite    = ctrlWe && ctrlWdata[CNT_W];
    earlyReload = activeQ && ctrlWe && (cnt > window);
    badLoad     = (activeQ || armWrite) && ctrlWe && !ctrlWdata[CNT_W-1];
    underflow   = activeQ && tick && !ctrlWe && (cnt == THRESH);
    warnSet     = tick && !ctrlWe && (cnt == NEAR);
    irq         = flagQ && irqEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      flagQ   <= 1'b0;
      rstReq  <= 1'b0;
    end else begin
      if (armWrite) activeQ <= 1'b1;
      if (warnSet)                      flagQ <= 1'b1;
      else if (flagWe && !flagWdata)    flagQ <= 1'b0;
      rstReq <= earlyReload || badLoad || underflow;
    end
  end
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import wwdg_pkg::*;
#(
  parameter int PRE_LOG2 = 12,
  parameter int TB_W     = 2,
  parameter int CNT_W    = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ctrlWe,
  input  logic [CNT_W:0]      ctrlWdata,
  input  logic                cfgWe,
  input  logic [CNT_W+TB_W:0] cfgWdata,
  input  logic                flagWe,
  input  logic                flagWdata,
  output logic [CNT_W:0]      ctrlRdata,
  output logic [CNT_W+TB_W:0] cfgRdata,
  output logic                flagRdata,
  output logic                rstReq,
  output logic                irq
);
  wdStrobe_t        strb;
  logic [CNT_W-1:0] cntVal, windowVal;
  logic [TB_W-1:0]  tbVal;
  logic             irqEn, tick, activeQ, flagQ;

  wwdg_datapath #(.PRE_LOG2(PRE_LOG2), .TB_W(TB_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .loadVal(ctrlWdata[CNT_W-1:0]), .cfgIn(cfgWdata),
    .cnt(cntVal), .window(windowVal), .tb(tbVal), .irqEn(irqEn), .tick(tick)
  );

  wwdg_control #(.CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .cfgWe(cfgWe), .flagWe(flagWe), .flagWdata(flagWdata),
    .cnt(cntVal), .window(windowVal), .irqEn(irqEn), .tick(tick),
    .strb(strb), .activeQ(activeQ), .flagQ(flagQ), .rstReq(rstReq), .irq(irq)
  );

  assign ctrlRdata = {activeQ, cntVal};
  assign cfgRdata  = {irqEn, tbVal, windowVal};
  assign flagRdata = flagQ;
endmodule

// File: rtl/wwdg_checker.sv
module wwdg_checker #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             ctrlWe,
  input logic [CNT_W:0]   ctrlWdata,
  input logic             flagWe,
  input logic             flagWdata,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] window,
  input logic             tick,
  input logic             activeQ,
  input logic             flagQ,
  input logic             rstReq
);
  localparam logic [CNT_W-1:0] THRESH = {1'b1, {(CNT_W-1){1'b0}}};

  a_r2_underflow_reset: assert property (@(posedge clk) disable iff (!rstN)
    activeQ && tick && !ctrlWe && cnt == THRESH |=> rstReq);

  a_r3_early_reload: assert property (@(posedge clk) disable iff (!rstN)
    activeQ && ctrlWe && cnt > window |=> rstReq);

  a_r4_valid_reload: assert property (@(posedge clk) disable iff (!rstN)
    activeQ && ctrlWe && ctrlWdata[CNT_W-1] && cnt <= window && cnt >= THRESH |=> !rstReq);

  a_r4_load_value: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWe |=> cnt == $past(ctrlWdata[CNT_W-1:0]));

  a_r5_disarmed_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !activeQ && !(ctrlWe && ctrlWdata[CNT_W]) |=> !rstReq);

  a_r9_arm_sticky: assert property (@(posedge clk) disable iff (!rstN)
    activeQ |=> activeQ);

  a_r8_flag_clear_source: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagQ) |-> $past(flagWe && !flagWdata));
endmodule

bind win_watchdog wwdg_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
  .flagWe(flagWe), .flagWdata(flagWdata), .cnt(cntVal), .window(windowVal),
  .tick(tick), .activeQ(activeQ), .flagQ(flagQ), .rstReq(rstReq)
);

// File: tb/win_watchdog_tb.sv
module win_watchdog_tb;
  localparam int PRE_LOG2 = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctrlWe = 1'b0;
  logic [7:0] ctrlWdata = '0;
  logic       cfgWe = 1'b0;
  logic [9:0] cfgWdata = '0;
  logic       flagWe = 1'b0;
  logic       flagWdata = 1'b0;
  logic [7:0] ctrlRdata;
  logic [9:0] cfgRdata;
  logic       flagRdata, rstReq, irq;

  int nChecks = 0;
  int nFail = 0;
  int rstSeen = 0;

  win_watchdog #(.PRE_LOG2(PRE_LOG2)) u_dut (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .cfgWe(cfgWe), .cfgWdata(cfgWdata), .flagWe(flagWe), .flagWdata(flagWdata),
    .ctrlRdata(ctrlRdata), .cfgRdata(cfgRdata), .flagRdata(flagRdata),
    .rstReq(rstReq), .irq(irq)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    #1;
    if (rstReq) rstSeen++;
  end

  function automatic int period(int tb);
    return 1 << (PRE_LOG2 + tb);
  endfunction

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrCtrl(logic arm, logic [6:0] v);
    @(negedge clk);
    ctrlWe = 1'b1; ctrlWdata = {arm, v};
    @(negedge clk);
    ctrlWe = 1'b0;
  endtask

  task automatic wrCfg(logic ie, logic [1:0] tb, logic [6:0] w);
    @(negedge clk);
    cfgWe = 1'b1; cfgWdata = {ie, tb, w};
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic wrFlag(logic d);
    @(negedge clk);
    flagWe = 1'b1; flagWdata = d;
    @(negedge clk);
    flagWe = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    int s, m, n, lv, w, k, kMax, cw, nl;
    void'($urandom(32'd4242));
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);
    // R1 reset state, R10 layout
    chk("R1 ctrl", ctrlRdata, 8'h7F);
    chk("R1 R10 cfg", cfgRdata, 10'h07F);
    chk("R1 flag", flagRdata, 0);
    chk("R1 rstReq", rstReq, 0);
    chk("R1 irq", irq, 0);

    // R11 / R5: disarmed counter runs through 0x3F without reset
    s = rstSeen;
    wrCtrl(1'b0, 7'h42);
    waitCyc(3 * period(0));
    chk("R11 count while disarmed", ctrlRdata, 8'h3F);
    chk("R5 no reset while disarmed", rstSeen - s, 0);

    // R6 tick period for each timebase
    for (int tb = 0; tb < 4; tb++) begin
      wrCfg(1'b0, 2'(tb), 7'h7F);
      wrCtrl(1'b0, 7'h7F);
      m = 1 + int'($urandom % 5);
      n = period(tb);
      waitCyc(m * n);
      chk("R6 count after ticks", ctrlRdata, 8'h7F - m);
      waitCyc(n - 1);
      chk("R6 no early tick", ctrlRdata, 8'h7F - m);
      waitCyc(1);
      chk("R6 tick at period", ctrlRdata, 8'h7F - m - 1);
    end

    // R10 configuration layout
    wrCfg(1'b1, 2'd2, 7'h55);
    chk("R10 cfg readback", cfgRdata, {1'b1, 2'd2, 7'h55});

    // arm with window 0x50
    wrCfg(1'b1, 2'd0, 7'h50);
    wrCtrl(1'b1, 7'h7F);
    chk("R5 arming write no reset", rstReq, 0);
    chk("R9 armed bit", ctrlRdata[7], 1);

    // R3 early reload
    wrCtrl(1'b1, 7'h7F);
    chk("R3 early reload reset", rstReq, 1);
    waitCyc(1);
    chk("R3 pulse one cycle", rstReq, 0);

    // R4 reload exactly at the window value
    waitCyc((8'h7F - 8'h50) * period(0) - 1);
    chk("R4 count at window", ctrlRdata[6:0], 7'h50);
    wrCtrl(1'b1, 7'h7F);
    chk("R4 in-window reload no reset", rstReq, 0);
    chk("R4 count reloaded", ctrlRdata[6:0], 7'h7F);

    // R9 arm bit sticky
    wrCfg(1'b1, 2'd0, 7'h7F);
    wrCtrl(1'b0, 7'h60);
    chk("R9 arm stays set", ctrlRdata[7], 1);
    chk("R4 reload no reset", rstReq, 0);

    // R7 load with bit 6 clear
    wrCtrl(1'b1, 7'h30);
    chk("R7 bad load reset", rstReq, 1);

    // R8 clear, then R2 underflow timing
    wrFlag(1'b0);
    chk("R8 flag cleared", flagRdata, 0);
    wrCtrl(1'b1, 7'h45);
    s = rstSeen;
    waitCyc(4 * period(0));
    chk("R8 no irq at 0x41", irq, 0);
    waitCyc(period(0));
    chk("R8 count 0x40", ctrlRdata[6:0], 7'h40);
    chk("R8 irq at 0x40", irq, 1);
    waitCyc(period(0) - 1);
    chk("R2 no reset before step", rstSeen - s, 0);
    waitCyc(1);
    chk("R2 reset at 0x3F", rstReq, 1);
    chk("R2 count 0x3F", ctrlRdata[6:0], 7'h3F);
    waitCyc(1);
    chk("R2 single pulse", rstReq, 0);

    // R8 masking and clear semantics
    wrCfg(1'b0, 2'd0, 7'h7F);
    chk("R8 irq masked", irq, 0);
    chk("R8 flag held", flagRdata, 1);
    wrFlag(1'b1);
    chk("R8 write 1 no effect", flagRdata, 1);
    wrFlag(1'b0);
    chk("R8 write 0 clears", flagRdata, 0);

    // random refresh sequences, R3/R4/R6
    for (int tb = 0; tb < 4; tb++) begin
      n = period(tb);
      wrCfg(1'b0, 2'(tb), 7'h7F);
      wrCtrl(1'b1, 7'h7F);
      lv = 8'h7F;
      for (int i = 0; i < 10; i++) begin
        kMax = (lv - 8'h3F) * n - 2;
        k = int'($urandom % (kMax + 1));
        waitCyc(k);
        chk("R6 random count", ctrlRdata[6:0], lv - k / n);
        w = 8'h40 + int'($urandom % 64);
        wrCfg(1'b0, 2'(tb), 7'(w));
        cw = lv - (k + 1) / n;
        nl = 8'h40 + int'($urandom % 64);
        wrCtrl(1'b1, 7'(nl));
        chk("R3 R4 random reload", rstReq, (cw > w) ? 1 : 0);
        lv = nl;
      end
    end

    finishRun();
  end
endmodule